// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the 16-bit fetch address of a small 8-bit Harvard-style processor. Each cycle the core may ask it to step forward by the length of the instruction just issued (one to three bytes), or to load a branch target. The program store is cut into 128-byte pages. When a forward step carries the address into a different page, the sequencer inserts one stall cycle before the new address is presented. Software never handles pages itself, and page boundaries show up only as an extra cycle.

A branch load never costs the extra cycle, even when it lands in another page or skips across several. A branch request also wins over a step request that arrives in the same cycle. While the stall is shown, step requests are dropped, and a branch request still takes effect.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-low reset sets the fetch address to 0000h and clears the stall flag in the cycle after the reset edge. This applies even when a stall is pending.
- R2: A step request (adv_req=1, adv_len in 1..3) with no branch and no stall, where the sum stays in the same page, makes the fetch address equal to the old address plus adv_len after the next edge, with stall low. An adv_len of 0 leaves the address unchanged.
- R3: A page is selected by address bits [15:7]. When the stepped address has different bits [15:7] from the current one, the edge after the request raises stall for exactly one cycle and the fetch address keeps its old value. The stepped address appears after the following edge, with stall low.
- R4: While stall is high, adv_req and adv_len are ignored. The address presented after the stall is the one computed before the stall, not one moved on further.
- R5: A step past FFFFh wraps modulo 2^16 and is treated as a page crossing, so it follows the R3 timing.
- R6: A branch request (jmp_req=1) loads jmp_addr as the fetch address after the next edge, with stall low. This holds whether the target is in the same page, the next page or a distant page.
- R7: When jmp_req and adv_req are both high in the same cycle, the branch target is loaded and the step is discarded.
- R8: A branch request made while stall is high loads jmp_addr after the next edge, cancels the pending stepped address and drops stall.
- R9: With no request, the fetch address holds and stall stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_req | input | 1 | Step forward by adv_len |
| adv_len | input | 2 | Length of the current instruction in bytes (1..3) |
| jmp_req | input | 1 | Load jmp_addr as the next fetch address |
| jmp_addr | input | 16 | Branch target |
| fetch_addr | output | 16 | Current fetch address |
| stall | output | 1 | Page-crossing stall cycle in progress |

## Verification
Several rules are checked by assertions on every cycle:
- the stall flag never lasts two cycles;
- the address stays frozen during a stall;
- an in-page step adds the length;
- a crossing step raises stall;
- a branch always lands with stall low.

Some behaviour can only be shown by the bench's scenarios:
- the exact address presented after a stall, including the wrap from FFFEh to 0000h;
- that a step offered during the stall is really dropped;
- that a branch made during the stall cancels the pending address.

The bench also covers the exact boundary cases 007Fh+1 and 007Dh+2.

// File: rtl/pc_seq_pkg.sv
// Package: shared types for the paged program counter sequencer.
// Assumes: address width 16, page size 2**7 bytes by default.
package pc_seq_pkg;

    // Source chosen for the next fetch address
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_STEP = 2'd1,
        SRC_JUMP = 2'd2,
        SRC_PEND = 2'd3
    } pc_src_e;

endpackage

// File: rtl/pc_next_calc.sv
// Module: pc_next_calc
// Computes the stepped address (current + length, modulo 2**ADDR_W)
// and flags whether the step leaves the current page or wraps.
// Assumes: LEN_W < ADDR_W, PAGE_BITS < ADDR_W.
module pc_next_calc #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 7,
    parameter int LEN_W     = 2
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  step_len,
    output logic [ADDR_W-1:0] step_addr,
    output logic              page_cross
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [ADDR_W:0]   sum_full;
    logic [PAGE_W-1:0] page_cur;
    logic [PAGE_W-1:0] page_nxt;

    // Add with carry-out so a wrap is seen even if page bits matched
    always_comb begin
        sum_full   = {1'b0, cur_addr} + {{(ADDR_W+1-LEN_W){1'b0}}, step_len};
        step_addr  = sum_full[ADDR_W-1:0];
        page_cur   = cur_addr[ADDR_W-1:PAGE_BITS];
        page_nxt   = sum_full[ADDR_W-1:PAGE_BITS];
        page_cross = sum_full[ADDR_W] | (page_cur != page_nxt);
    end

endmodule

// File: rtl/pc_stall_ctrl.sv
// Module: pc_stall_ctrl
// Holds the one-cycle stall and the stepped address that waits behind it.
// Assumes: caller only raises cross_take when no stall is pending.
module pc_stall_ctrl #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cross_take,
    input  logic [ADDR_W-1:0] cross_addr,
    output logic              pend_q,
    output logic [ADDR_W-1:0] pend_addr_q
);

    // Arm the stall for one cycle on an accepted crossing step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= cross_take;
        end
    end

    // Capture the address to present once the stall ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr_q <= '0;
        end else if (cross_take) begin
            pend_addr_q <= cross_addr;
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
// Module: pc_sequencer (top)
// 16-bit fetch address register with sequential step, branch load and a
// one-cycle stall whenever a step moves into another page.
// Assumes: adv_len is 1..3 (0 means no movement); branch wins over step;
// step requests during a stall are dropped.
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 7,
    parameter int LEN_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_req,
    input  logic [LEN_W-1:0]  adv_len,
    input  logic              jmp_req,
    input  logic [ADDR_W-1:0] jmp_addr,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              stall
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] step_addr;
    logic              page_cross;
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              step_ok;
    logic              cross_take;
    pc_src_e           src_sel;

    pc_next_calc #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .LEN_W     (LEN_W)
    ) u_calc (
        .cur_addr   (pc_q),
        .step_len   (adv_len),
        .step_addr  (step_addr),
        .page_cross (page_cross)
    );

    pc_stall_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .cross_take  (cross_take),
        .cross_addr  (step_addr),
        .pend_q      (pend_q),
        .pend_addr_q (pend_addr_q)
    );

    // Qualify the step request and pick the next address source
    always_comb begin
        step_ok    = adv_req && !jmp_req && !pend_q && (adv_len != '0);
        cross_take = step_ok && page_cross;
        if (jmp_req)                   src_sel = SRC_JUMP;
        else if (pend_q)               src_sel = SRC_PEND;
        else if (step_ok && !page_cross) src_sel = SRC_STEP;
        else                           src_sel = SRC_HOLD;
    end

    // Fetch address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            case (src_sel)
                SRC_JUMP: pc_q <= jmp_addr;
                SRC_PEND: pc_q <= pend_addr_q;
                SRC_STEP: pc_q <= step_addr;
                default:  pc_q <= pc_q;
            endcase
        end
    end

    assign fetch_addr = pc_q;
    assign stall      = pend_q;

    // Independent page check used by the assertions below
    logic [ADDR_W:0] chk_sum;
    logic            chk_same_page;
    always_comb begin
        chk_sum       = {1'b0, fetch_addr} + (ADDR_W+1)'(adv_len);
        chk_same_page = (chk_sum[ADDR_W:PAGE_BITS] == {1'b0, fetch_addr[ADDR_W-1:PAGE_BITS]});
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr == '0 && !stall));

    // R3
    stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R3
    stall_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $stable(fetch_addr));

    // R2
    step_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_req && !jmp_req && !stall && chk_same_page)
        |=> (!stall && fetch_addr == $past(chk_sum[ADDR_W-1:0])));

    // R3
    step_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_req && !jmp_req && !stall && !chk_same_page) |=> stall);

    // R6
    jump_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_req |=> (!stall && fetch_addr == $past(jmp_addr)));

endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv_req;
    logic [1:0]  adv_len;
    logic        jmp_req;
    logic [15:0] jmp_addr;
    logic [15:0] fetch_addr;
    logic        stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_req    (adv_req),
        .adv_len    (adv_len),
        .jmp_req    (jmp_req),
        .jmp_addr   (jmp_addr),
        .fetch_addr (fetch_addr),
        .stall      (stall)
    );

    // Drive one cycle of inputs at the falling edge, then sample after the rising edge
    task automatic step(input bit rst, input bit adv, input logic [1:0] len,
                        input bit jmp, input logic [15:0] tgt);
        @(negedge clk);
        rst_n    = ~rst;
        adv_req  = adv;
        adv_len  = len;
        jmp_req  = jmp;
        jmp_addr = tgt;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
    endtask

    task automatic expect_state(input string req, input logic [15:0] exp_a, input bit exp_s);
        checks++;
        if (fetch_addr !== exp_a || stall !== exp_s) begin
            errors++;
            $display("FAIL %s: addr=%h stall=%b expected addr=%h stall=%b",
                     req, fetch_addr, stall, exp_a, exp_s);
        end
    endtask

    task automatic t_reset();
        step(1'b1, 1'b0, 2'd0, 1'b0, 16'h0);
        expect_state("R1", 16'h0000, 1'b0);
        idle();
        expect_state("R9", 16'h0000, 1'b0);
    endtask

    task automatic t_sequential();
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h0010);
        expect_state("R6", 16'h0010, 1'b0);
        step(1'b0, 1'b1, 2'd1, 1'b0, 16'h0);
        expect_state("R2", 16'h0011, 1'b0);
        step(1'b0, 1'b1, 2'd2, 1'b0, 16'h0);
        expect_state("R2", 16'h0013, 1'b0);
        step(1'b0, 1'b1, 2'd3, 1'b0, 16'h0);
        expect_state("R2", 16'h0016, 1'b0);
        step(1'b0, 1'b1, 2'd0, 1'b0, 16'h0);
        expect_state("R2", 16'h0016, 1'b0);
        idle();
        expect_state("R9", 16'h0016, 1'b0);
    endtask

    task automatic t_cross();
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h007D);
        step(1'b0, 1'b1, 2'd2, 1'b0, 16'h0);
        expect_state("R2", 16'h007F, 1'b0);
        step(1'b0, 1'b1, 2'd1, 1'b0, 16'h0);
        expect_state("R3", 16'h007F, 1'b1);
        // R4: step offered during the stall must be dropped
        step(1'b0, 1'b1, 2'd3, 1'b0, 16'h0);
        expect_state("R4", 16'h0080, 1'b0);
        idle();
        expect_state("R4", 16'h0080, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h017E);
        step(1'b0, 1'b1, 2'd3, 1'b0, 16'h0);
        expect_state("R3", 16'h017E, 1'b1);
        idle();
        expect_state("R3", 16'h0181, 1'b0);
    endtask

    task automatic t_wrap();
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'hFFFE);
        step(1'b0, 1'b1, 2'd2, 1'b0, 16'h0);
        expect_state("R5", 16'hFFFE, 1'b1);
        idle();
        expect_state("R5", 16'h0000, 1'b0);
    endtask

    task automatic t_jump_pages();
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h007F);
        expect_state("R6", 16'h007F, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h0080);
        expect_state("R6", 16'h0080, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'hA5C3);
        expect_state("R6", 16'hA5C3, 1'b0);
    endtask

    task automatic t_priority();
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h007F);
        step(1'b0, 1'b1, 2'd1, 1'b1, 16'h0200);
        expect_state("R7", 16'h0200, 1'b0);
        idle();
        expect_state("R7", 16'h0200, 1'b0);
    endtask

    task automatic t_jump_in_stall();
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h00FF);
        step(1'b0, 1'b1, 2'd1, 1'b0, 16'h0);
        expect_state("R3", 16'h00FF, 1'b1);
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h1234);
        expect_state("R8", 16'h1234, 1'b0);
        idle();
        expect_state("R8", 16'h1234, 1'b0);
    endtask

    task automatic t_reset_in_stall();
        step(1'b0, 1'b0, 2'd0, 1'b1, 16'h0C7F);
        step(1'b0, 1'b1, 2'd1, 1'b0, 16'h0);
        expect_state("R3", 16'h0C7F, 1'b1);
        step(1'b1, 1'b0, 2'd0, 1'b0, 16'h0);
        expect_state("R1", 16'h0000, 1'b0);
        idle();
        expect_state("R1", 16'h0000, 1'b0);
    endtask

    initial begin
        rst_n    = 1'b0;
        adv_req  = 1'b0;
        adv_len  = 2'd0;
        jmp_req  = 1'b0;
        jmp_addr = 16'h0;
        t_reset();
        t_sequential();
        t_cross();
        t_wrap();
        t_jump_pages();
        t_priority();
        t_jump_in_stall();
        t_reset_in_stall();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule